// File: doc/BRIEF.md
# Five-Bit Frame Serial Parity Checker

This block takes a serial bit stream, one bit per enabled clock, and cuts it into back-to-back groups of five bits that never overlap. At the moment the fifth bit of a group is presented, the output rises for that cycle if the group held an odd number of ones. At the first four positions of every group the output stays low, and it also stays low when a completed group is even. After the fifth bit the block begins the next group with a clean parity.

A qualifier input tells the block which clock cycles carry a data bit. In cycles where it is low, the block takes nothing in and its frame position does not move. A synchronous reset drops any partly collected group. The next qualified bit after reset is the first bit of a new group.

Internally a two-state sequencer tracks frame position. In `ST_FILL` it is collecting bits one to four. In `ST_LAST` it expects the closing bit. The transitions are FILL→FILL (a qualified bit that is not the fourth), FILL→LAST (the fourth qualified bit), LAST→FILL (the fifth qualified bit), and a hold in place on any unqualified cycle. A separate accumulator keeps the running XOR of the bits taken so far. The result is formed combinationally from the accumulator and the bit currently on the input.

Top module: `frame_parity_chk`

## Requirements
- R1: While `rst` is high at a rising edge, the block returns to the first position of a group with cleared parity; `odd_flag` is 0 in any cycle where `rst` is high.
- R2: `odd_flag` is 0 whenever the bit on the input is at position 1, 2, 3 or 4 of a group, regardless of the data.
- R3: When a qualified bit is the 5th of its group, `odd_flag` is 1 in that same cycle if the five bits, including the current one, contain an odd number of ones.
- R4: When a qualified 5th bit completes a group with an even number of ones (0, 2 or 4), `odd_flag` is 0.
- R5: Groups do not overlap: the qualified bit after a 5th bit is position 1 of a new group, and its parity starts from zero.
- R6: In a cycle with `bit_en` low, `bit_in` is ignored, the frame position and parity hold, and `odd_flag` is 0.
- R7: A reset in the middle of a group discards the bits taken so far; the following five qualified bits form a complete group of their own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial data bit |
| bit_en | input | 1 | High when `bit_in` carries a bit this cycle |
| odd_flag | output | 1 | High on the 5th bit of a group whose ones count is odd |

## Verification
The hardest case to reach is a 5th-bit cycle where the frame position and the parity reach that point across gaps in `bit_en`. A gap can fall right at the closing position, with a one on `bit_in` that must not be taken. To get there, the stimulus opens directed gaps at every position, including the last, with data set to one. It then runs a long stretch with both the qualifier and the data random, so every gap length meets every position. A reset is also dropped at the fourth position so that the closing position is reached from a discarded partial group.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    // Phase of the frame sequencer
    typedef enum logic {
        ST_FILL = 1'b0,   // collecting positions 1 .. FRAME_LEN-1
        ST_LAST = 1'b1    // next qualified bit closes the frame
    } fpc_state_e;

endpackage

// File: rtl/fpc_seq.sv
module fpc_seq
    import fpc_pkg::*;
#(
    parameter int FRAME_LEN = 5,
    parameter int POS_W     = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output fpc_state_e       state,
    output logic [POS_W-1:0] pos,
    output logic             at_last
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);
    localparam logic [POS_W-1:0] PRE_LAST = POS_W'(FRAME_LEN - 2);

    fpc_state_e       state_nx;
    logic [POS_W-1:0] pos_nx;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FILL;
            pos   <= '0;
        end else begin
            state <= state_nx;
            pos   <= pos_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        pos_nx   = pos;
        unique case (state)
            ST_FILL: begin
                if (step) begin
                    pos_nx = pos + 1'b1;
                    if (pos == PRE_LAST) begin
                        state_nx = ST_LAST;
                    end
                end
            end
            ST_LAST: begin
                if (step) begin
                    state_nx = ST_FILL;
                    pos_nx   = '0;
                end
            end
            default: begin
                state_nx = ST_FILL;
                pos_nx   = '0;
            end
        endcase
    end

    // Output decode
    always_comb begin
        at_last = (state == ST_LAST);
    end

    // R1: reset lands on the first frame position
    p_reset_home_r1: assert property (@(posedge clk)
        rst |=> (pos == '0) && (state == ST_FILL));

    // R5: closing phase and counter agree
    p_last_pos_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LAST) |-> (pos == LAST_POS));

    // R5: closing bit wraps the counter
    p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (step && state == ST_LAST) |=> (pos == '0) && (state == ST_FILL));

    // R6: no qualified bit, no movement
    p_hold_pos_r6: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(pos) && $stable(state));

endmodule

// File: rtl/fpc_acc.sv
module fpc_acc (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic closing,
    input  logic bit_in,
    output logic par
);

    always_ff @(posedge clk) begin
        if (rst) begin
            par <= 1'b0;
        end else if (step) begin
            if (closing) begin
                par <= 1'b0;
            end else begin
                par <= par ^ bit_in;
            end
        end
    end

    // R5: next frame starts with cleared parity
    p_fresh_frame_r5: assert property (@(posedge clk) disable iff (rst)
        (step && closing) |=> !par);

    // R6: an ignored bit leaves the parity alone
    p_hold_par_r6: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(par));

endmodule

// File: rtl/frame_parity_chk.sv
module frame_parity_chk
    import fpc_pkg::*;
#(
    parameter int FRAME_LEN = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    input  logic bit_en,
    output logic odd_flag
);

    localparam int POS_W = $clog2(FRAME_LEN);

    fpc_state_e       state;
    logic [POS_W-1:0] pos;
    logic             at_last;
    logic             par;

    fpc_seq #(
        .FRAME_LEN (FRAME_LEN),
        .POS_W     (POS_W)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .step    (bit_en),
        .state   (state),
        .pos     (pos),
        .at_last (at_last)
    );

    fpc_acc u_acc (
        .clk     (clk),
        .rst     (rst),
        .step    (bit_en),
        .closing (at_last),
        .bit_in  (bit_in),
        .par     (par)
    );

    // Result includes the closing bit itself
    always_comb begin
        odd_flag = !rst && bit_en && at_last && (par ^ bit_in);
    end

    // R2: silent before the closing position
    p_quiet_fill_r2: assert property (@(posedge clk) disable iff (rst)
        !at_last |-> !odd_flag);

    // R6: silent on unqualified cycles
    p_quiet_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !bit_en |-> !odd_flag);

    // R1: silent during reset
    p_quiet_reset_r1: assert property (@(posedge clk)
        rst |-> !odd_flag);

endmodule

// File: tb/frame_parity_chk_tb.sv
module frame_parity_chk_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_in = 1'b0;
    logic bit_en = 1'b0;
    logic odd_flag;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    // Behavioural reference state
    int m_pos = 0;
    int m_ones = 0;

    always #5 clk = ~clk;

    frame_parity_chk u_dut (
        .clk      (clk),
        .rst      (rst),
        .bit_in   (bit_in),
        .bit_en   (bit_en),
        .odd_flag (odd_flag)
    );

    always @(posedge clk) cycles++;

    // One cycle: drive at negedge, check before the edge, advance model at the edge
    task automatic step(input bit r, input bit en, input bit b, input string tag_over);
        string tag;
        bit exp;
        @(negedge clk);
        rst = r; bit_en = en; bit_in = b;
        #4;
        exp = !r && en && (m_pos == 4) && (((m_ones + b) % 2) == 1);
        if (tag_over != "") tag = tag_over;
        else if (r) tag = "R1";
        else if (!en) tag = "R6";
        else if (m_pos != 4) tag = "R2";
        else if (exp) tag = "R3";
        else tag = "R4";
        n_checks++;
        if (odd_flag !== exp) begin
            n_fail++;
            $display("FAIL %s: pos=%0d odd_flag=%b expected=%b", tag, m_pos, odd_flag, exp);
        end
        @(posedge clk);
        if (r) begin
            m_pos = 0; m_ones = 0;
        end else if (en) begin
            if (m_pos == 4) begin
                m_pos = 0; m_ones = 0;
            end else begin
                m_pos++; m_ones += b;
            end
        end
    endtask

    task automatic frame(input bit [4:0] v, input string tag);
        for (int i = 4; i >= 0; i--) step(1'b0, 1'b1, v[i], (i == 0) ? tag : "");
    endtask

    initial begin
        // R1: reset state
        step(1'b1, 1'b0, 1'b0, "R1");
        step(1'b1, 1'b1, 1'b1, "R1");
        // R4 / R3 basic frames
        frame(5'b00000, "R4");
        frame(5'b11111, "R3");
        frame(5'b10000, "R3");
        frame(5'b00001, "R3");
        frame(5'b11000, "R4");
        frame(5'b01111, "R4");
        frame(5'b10101, "R3");
        // R5: back-to-back odd frames must not carry parity
        frame(5'b00001, "R5");
        frame(5'b00000, "R5");
        frame(5'b10000, "R5");
        // R6: gaps at every position with data = 1
        for (int g = 0; g < 5; g++) begin
            for (int i = 0; i < 5; i++) begin
                if (i == g) begin
                    step(1'b0, 1'b0, 1'b1, "R6");
                    step(1'b0, 1'b0, 1'b1, "R6");
                end
                step(1'b0, 1'b1, (i == 1), "");
            end
        end
        // R7: reset after four bits, then a full fresh frame
        step(1'b0, 1'b1, 1'b1, "");
        step(1'b0, 1'b1, 1'b0, "");
        step(1'b0, 1'b1, 1'b0, "");
        step(1'b0, 1'b1, 1'b0, "");
        step(1'b1, 1'b1, 1'b1, "R7");
        frame(5'b00001, "R7");
        step(1'b0, 1'b1, 1'b1, "");
        step(1'b0, 1'b1, 1'b1, "");
        step(1'b1, 1'b0, 1'b0, "R7");
        frame(5'b01100, "R7");
        // Random stretch
        for (int k = 0; k < 3000; k++) begin
            step(($urandom_range(0, 199) == 0), ($urandom_range(0, 3) != 0),
                 1'($urandom_range(0, 1)), "");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected=<100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule